// File: doc/BRIEF.md
# Display Data Channel Clock-Ratio Snooper

This block listens to the two-wire display data channel that runs between a video source and a sink. It never drives either line. It follows every transaction on the bus and picks out acknowledged writes that the source sends to the sink's status and configuration device, at the register that holds the clock-ratio request. One chosen bit of the byte written to that register sets a local status flag. A flag value of 1 selects a TMDS clock of one fortieth of the bit rate. A flag value of 0 selects one tenth of the bit rate.

The flag goes back to its default of 0 whenever hot-plug-detect is low. A snoop-disable input lets host logic bypass the snooped traffic. While snoop-disable is high, the flag copies a forced value. The bus lines arrive unsynchronized, and the block re-times them to its own clock before decoding. For reliable decoding, each SCL phase must last several core clock cycles.

Top module: `ddc_ratio_snoop`

## Requirements
- R1: After reset, ratio40_o is 0.
- R2: An acknowledged write to 8-bit device address 0xA8 (7-bit address 0x54, R/W bit 0), whose register offset byte is 0x20, loads bit 1 of the data byte into ratio40_o. A 1 gives the 1/40 ratio and a 0 gives the 1/10 ratio.
- R3: In a write, the first byte after the address is the register offset. Each later data byte goes to the next offset in turn. Only the data byte that lands on offset 0x20 is used.
- R4: A read (address byte 0xA9), or a write to any other device address, leaves ratio40_o unchanged.
- R5: SDA high in the ninth (acknowledge) bit of a byte is a NACK. A NACK aborts the transaction. The NACKed byte and every later byte up to the next START are ignored.
- R6: Data bits are sampled on the rising edge of SCL, most significant bit first. A new flag value appears only after the acknowledge bit of the matching byte. A START (SDA falls while SCL is high) or a STOP (SDA rises while SCL is high) in the middle of a byte discards that partial byte.
- R7: A repeated START restarts address decoding, so the address byte that follows it decides whether the rest of the transaction is watched.
- R8: While hpd_i is 0, ratio40_o is driven to 0 within one clock, and snooped writes are ignored. Raising hpd_i again does not restore the old value.
- R9: While snoop_dis_i is 1 and hpd_i is 1, ratio40_o follows force_val_i one clock later, and snooped writes are ignored. When snoop_dis_i returns to 0, the flag keeps its last value until the next matching write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Sampled bus clock line, asynchronous |
| sda_i | input | 1 | Sampled bus data line, asynchronous |
| hpd_i | input | 1 | Hot-plug-detect level; low clears the flag |
| snoop_dis_i | input | 1 | 1 = ignore bus traffic and use force_val_i |
| force_val_i | input | 1 | Flag value used while snooping is disabled |
| ratio40_o | output | 1 | Clock-ratio status: 1 = 1/40, 0 = 1/10 |

## Verification
The bench sweeps write bursts that start at every offset from 0x1D to 0x21 and carry one to four data bytes. The bit-1 value alternates between bytes, so the sweep shows whether exactly the byte that lands on 0x20 is used, or a neighbouring byte, or none. Read transactions and writes to other device addresses are sent with payloads that would clear the flag. These tell apart correct address filtering from address matching that ignores the R/W bit or one address bit. NACKs are placed on the address byte and on the matching data byte, and truncated bytes are ended by STOP or by START, to show that capture is aborted. Hot-plug, override and repeated-START sequences check the priority between snooped writes, hot-plug clearing and forced values.

// File: rtl/ddc_snoop_pkg.sv
package ddc_snoop_pkg;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = $clog2(BYTE_W + 1);

  typedef enum logic [1:0] {
    PH_ADDR = 2'd0,
    PH_OFFS = 2'd1,
    PH_DATA = 2'd2,
    PH_SKIP = 2'd3
  } snoop_phase_e;
endpackage

// File: rtl/ddc_line_sync.sv
module ddc_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_o,
  output logic scl_rise_o,
  output logic start_o,
  output logic stop_o
);
  // bit 1 = scl, bit 0 = sda; idle bus is high
  logic [STAGES-1:0][1:0] chain_q;
  logic [1:0]             prev_q;
  logic [1:0]             cur;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chain_q <= '1;
      prev_q  <= 2'b11;
    end else begin
      for (int k = STAGES - 1; k > 0; k--) chain_q[k] <= chain_q[k-1];
      chain_q[0] <= {scl_i, sda_i};
      prev_q     <= chain_q[STAGES-1];
    end
  end

  assign cur        = chain_q[STAGES-1];
  assign sda_o      = cur[0];
  assign scl_rise_o = cur[1] & ~prev_q[1];
  assign start_o    = cur[1] & prev_q[1] & prev_q[0] & ~cur[0];
  assign stop_o     = cur[1] & prev_q[1] & ~prev_q[0] & cur[0];
endmodule

// File: rtl/ddc_bit_framer.sv
module ddc_bit_framer
  import ddc_snoop_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sda_i,
  input  logic              scl_rise_i,
  input  logic              start_i,
  input  logic              stop_i,
  output logic [BYTE_W-1:0] byte_o,
  output logic              byte_ok_o,
  output logic              byte_nak_o,
  output logic [CNT_W-1:0]  bit_cnt_o
);
  logic              active_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [BYTE_W-1:0] shift_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q   <= 1'b0;
      cnt_q      <= '0;
      shift_q    <= '0;
      byte_ok_o  <= 1'b0;
      byte_nak_o <= 1'b0;
    end else begin
      byte_ok_o  <= 1'b0;
      byte_nak_o <= 1'b0;
      if (start_i) begin
        active_q <= 1'b1;
        cnt_q    <= '0;
      end else if (stop_i) begin
        active_q <= 1'b0;
        cnt_q    <= '0;
      end else if (active_q && scl_rise_i) begin
        if (cnt_q == CNT_W'(BYTE_W)) begin
          // acknowledge slot: low = ACK
          cnt_q      <= '0;
          byte_ok_o  <= ~sda_i;
          byte_nak_o <= sda_i;
        end else begin
          shift_q <= {shift_q[BYTE_W-2:0], sda_i};
          cnt_q   <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign byte_o    = shift_q;
  assign bit_cnt_o = cnt_q;
endmodule

// File: rtl/ddc_reg_tracker.sv
module ddc_reg_tracker
  import ddc_snoop_pkg::*;
#(
  parameter logic [6:0]        DEV_ADDR = 7'h54,
  parameter logic [BYTE_W-1:0] REG_OFF  = 8'h20,
  parameter int                SEL_BIT  = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic              byte_ok_i,
  input  logic              byte_nak_i,
  input  logic              hpd_i,
  input  logic              snoop_dis_i,
  input  logic              force_val_i,
  output logic              flag_o
);
  localparam logic [BYTE_W-1:0] WR_ADDR = {DEV_ADDR, 1'b0};

  snoop_phase_e      phase_q;
  logic [BYTE_W-1:0] ptr_q;
  logic              hit;

  assign hit = byte_ok_i && (phase_q == PH_DATA) && (ptr_q == REG_OFF);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_SKIP;
      ptr_q   <= '0;
    end else if (start_i) begin
      phase_q <= PH_ADDR;
    end else if (stop_i || byte_nak_i) begin
      phase_q <= PH_SKIP;
    end else if (byte_ok_i) begin
      unique case (phase_q)
        PH_ADDR: phase_q <= (byte_i == WR_ADDR) ? PH_OFFS : PH_SKIP;
        PH_OFFS: begin
          ptr_q   <= byte_i;
          phase_q <= PH_DATA;
        end
        PH_DATA: ptr_q <= ptr_q + 1'b1;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          flag_o <= 1'b0;
    else if (!hpd_i)      flag_o <= 1'b0;
    else if (snoop_dis_i) flag_o <= force_val_i;
    else if (hit)         flag_o <= byte_i[SEL_BIT];
  end
endmodule

// File: rtl/ddc_ratio_snoop.sv
module ddc_ratio_snoop
  import ddc_snoop_pkg::*;
#(
  parameter int                SYNC_STAGES = 2,
  parameter logic [6:0]        DEV_ADDR    = 7'h54,
  parameter logic [BYTE_W-1:0] REG_OFF     = 8'h20,
  parameter int                SEL_BIT     = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  input  logic hpd_i,
  input  logic snoop_dis_i,
  input  logic force_val_i,
  output logic ratio40_o
);
  logic              sda_s;
  logic              scl_rise;
  logic              bus_start;
  logic              bus_stop;
  logic [BYTE_W-1:0] rx_byte;
  logic              byte_ok;
  logic              byte_nak;
  logic [CNT_W-1:0]  bit_cnt;

  ddc_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .sda_o      (sda_s),
    .scl_rise_o (scl_rise),
    .start_o    (bus_start),
    .stop_o     (bus_stop)
  );

  ddc_bit_framer u_framer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sda_i      (sda_s),
    .scl_rise_i (scl_rise),
    .start_i    (bus_start),
    .stop_i     (bus_stop),
    .byte_o     (rx_byte),
    .byte_ok_o  (byte_ok),
    .byte_nak_o (byte_nak),
    .bit_cnt_o  (bit_cnt)
  );

  ddc_reg_tracker #(
    .DEV_ADDR (DEV_ADDR),
    .REG_OFF  (REG_OFF),
    .SEL_BIT  (SEL_BIT)
  ) u_track (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (bus_start),
    .stop_i      (bus_stop),
    .byte_i      (rx_byte),
    .byte_ok_i   (byte_ok),
    .byte_nak_i  (byte_nak),
    .hpd_i       (hpd_i),
    .snoop_dis_i (snoop_dis_i),
    .force_val_i (force_val_i),
    .flag_o      (ratio40_o)
  );
endmodule

// File: rtl/ddc_ratio_snoop_chk.sv
module ddc_ratio_snoop_chk
  import ddc_snoop_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             hpd_i,
  input logic             snoop_dis_i,
  input logic             force_val_i,
  input logic             ratio40_o,
  input logic             byte_ok_i,
  input logic [CNT_W-1:0] bit_cnt_i
);
  a_r8_hpd_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hpd_i |=> !ratio40_o);

  a_r9_force_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hpd_i && snoop_dis_i) |=> (ratio40_o == $past(force_val_i)));

  a_r6_hold_without_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hpd_i && !snoop_dis_i && !byte_ok_i) |=> $stable(ratio40_o));

  a_r6_bit_count_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_cnt_i <= CNT_W'(BYTE_W));
endmodule

bind ddc_ratio_snoop ddc_ratio_snoop_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .hpd_i       (hpd_i),
  .snoop_dis_i (snoop_dis_i),
  .force_val_i (force_val_i),
  .ratio40_o   (ratio40_o),
  .byte_ok_i   (byte_ok),
  .bit_cnt_i   (bit_cnt)
);

// File: tb/ddc_ratio_snoop_tb_top.sv
module ddc_ratio_snoop_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int Q          = 4;
  localparam int WATCHDOG   = 150000;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic scl = 1'b1, sda = 1'b1;
  logic hpd = 1'b1, sdis = 1'b0, fval = 1'b0;
  logic ratio40;
  int   checks = 0, fails = 0;
  bit   done = 1'b0;
  bit   exp_flag;

  always #(CLK_PERIOD/2) clk = ~clk;

  ddc_ratio_snoop dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .scl_i(scl), .sda_i(sda),
    .hpd_i(hpd), .snoop_dis_i(sdis), .force_val_i(fval), .ratio40_o(ratio40)
  );

  task automatic hold(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit exp, input string req);
    checks++;
    if (ratio40 !== exp) begin
      fails++;
      $display("FAIL %s ratio40_o=%0b expected=%0b", req, ratio40, exp);
    end
  endtask

  task automatic bus_start();
    sda = 1'b1; hold(Q); scl = 1'b1; hold(Q); sda = 1'b0; hold(Q); scl = 1'b0; hold(Q);
  endtask

  task automatic bus_stop();
    sda = 1'b0; hold(Q); scl = 1'b1; hold(Q); sda = 1'b1; hold(Q + 4);
  endtask

  task automatic send_bit(input bit b);
    sda = b; hold(Q); scl = 1'b1; hold(Q); scl = 1'b0; hold(Q);
  endtask

  task automatic send_byte(input logic [7:0] d, input bit ack);
    for (int i = 7; i >= 0; i--) send_bit(d[i]);
    send_bit(!ack);
  endtask

  function automatic logic [7:0] dbyte(input int pat, input int k);
    return (((pat ^ k) & 1) != 0) ? 8'hA6 : 8'h59;  // bit1: A6 -> 1, 59 -> 0
  endfunction

  task automatic write_seq(input logic [7:0] addr, input logic [7:0] off,
                           input int len, input int pat);
    bus_start();
    send_byte(addr, 1'b1);
    send_byte(off, 1'b1);
    for (int k = 0; k < len; k++) send_byte(dbyte(pat, k), 1'b1);
    bus_stop();
  endtask

  initial begin : watchdog
    for (int c = 0; c < WATCHDOG; c++) begin
      @(posedge clk);
      if (done) disable watchdog;
    end
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    hold(5);
    chk(1'b0, "R1 flag in reset");
    rst_ni = 1'b1;
    hold(5);
    chk(1'b0, "R1 flag after reset");

    // R2 basic set and clear
    write_seq(8'hA8, 8'h20, 1, 1);
    chk(1'b1, "R2 write bit1=1");
    write_seq(8'hA8, 8'h20, 1, 0);
    chk(1'b0, "R2 write bit1=0");
    exp_flag = 1'b0;

    // R3 offset auto-increment sweep
    for (int off = 8'h1D; off <= 8'h21; off++)
      for (int len = 1; len <= 4; len++)
        for (int pat = 0; pat < 2; pat++) begin
          write_seq(8'hA8, 8'(off), len, pat);
          if (off <= 8'h20 && 8'h20 < off + len)
            exp_flag = dbyte(pat, 8'h20 - off) >> 1;
          chk(exp_flag, $sformatf("R3 off=%0h len=%0d pat=%0d", off, len, pat));
        end

    // R4 reads and foreign addresses: set 1, then try to clear
    write_seq(8'hA8, 8'h20, 1, 1);
    chk(1'b1, "R2 set before R4");
    write_seq(8'hA9, 8'h20, 2, 0);
    chk(1'b1, "R4 read address 0xA9");
    write_seq(8'hAA, 8'h20, 1, 0);
    chk(1'b1, "R4 address 0xAA");
    write_seq(8'h28, 8'h20, 1, 0);
    chk(1'b1, "R4 address 0x28");
    write_seq(8'hA0, 8'h20, 1, 0);
    chk(1'b1, "R4 address 0xA0");

    // R5 NACK on address byte
    bus_start(); send_byte(8'hA8, 1'b0); send_byte(8'h20, 1'b1);
    send_byte(8'h59, 1'b1); bus_stop();
    chk(1'b1, "R5 NACK on address");
    // R5 NACK on matching data byte
    bus_start(); send_byte(8'hA8, 1'b1); send_byte(8'h20, 1'b1);
    send_byte(8'h59, 1'b0); bus_stop();
    chk(1'b1, "R5 NACK on data");
    // R5 NACK on offset byte, later bytes ignored
    bus_start(); send_byte(8'hA8, 1'b1); send_byte(8'h20, 1'b0);
    send_byte(8'h20, 1'b1); send_byte(8'h59, 1'b1); bus_stop();
    chk(1'b1, "R5 NACK on offset");

    // R6 update only after ack slot
    bus_start(); send_byte(8'hA8, 1'b1); send_byte(8'h20, 1'b1);
    for (int i = 7; i >= 0; i--) send_bit(i == 1 ? 1'b0 : 1'b1);
    chk(1'b1, "R6 before ack slot");
    send_bit(1'b0);
    chk(1'b0, "R6 after ack slot");
    bus_stop();
    // R6 partial byte ended by STOP
    bus_start(); send_byte(8'hA8, 1'b1); send_byte(8'h20, 1'b1);
    for (int i = 0; i < 7; i++) send_bit(1'b1);
    bus_stop();
    chk(1'b0, "R6 partial byte then STOP");
    // R6 partial byte ended by START
    bus_start(); send_byte(8'hA8, 1'b1); send_byte(8'h20, 1'b1);
    for (int i = 0; i < 7; i++) send_bit(1'b1);
    bus_start(); bus_stop();
    chk(1'b0, "R6 partial byte then START");

    // R7 repeated START into a read: ignored
    bus_start(); send_byte(8'hA8, 1'b1); send_byte(8'h20, 1'b1);
    bus_start(); send_byte(8'hA9, 1'b1); send_byte(8'hA6, 1'b1); send_byte(8'hA6, 1'b1);
    bus_stop();
    chk(1'b0, "R7 restart into read");
    // R7 foreign address then repeated START to watched address
    bus_start(); send_byte(8'hAA, 1'b1); send_byte(8'h20, 1'b1);
    bus_start(); send_byte(8'hA8, 1'b1); send_byte(8'h20, 1'b1); send_byte(8'hA6, 1'b1);
    bus_stop();
    chk(1'b1, "R7 restart into watched write");

    // R8 hot-plug
    hpd = 1'b0; hold(2);
    chk(1'b0, "R8 hpd low clears");
    write_seq(8'hA8, 8'h20, 1, 1);
    chk(1'b0, "R8 write ignored while hpd low");
    hpd = 1'b1; hold(3);
    chk(1'b0, "R8 hpd high keeps default");
    write_seq(8'hA8, 8'h20, 1, 1);
    chk(1'b1, "R8 write after hpd return");

    // R9 override
    sdis = 1'b1; fval = 1'b0; hold(2);
    chk(1'b0, "R9 force 0");
    write_seq(8'hA8, 8'h20, 1, 1);
    chk(1'b0, "R9 write ignored while disabled");
    fval = 1'b1; hold(2);
    chk(1'b1, "R9 force 1");
    write_seq(8'hA8, 8'h20, 1, 0);
    chk(1'b1, "R9 clear ignored while disabled");
    sdis = 1'b0; hold(3);
    chk(1'b1, "R9 value kept after release");
    write_seq(8'hA8, 8'h20, 1, 0);
    chk(1'b0, "R9 snooping resumes");
    hpd = 1'b0; sdis = 1'b1; fval = 1'b1; hold(3);
    chk(1'b0, "R8 hpd low beats override");
    hpd = 1'b1; sdis = 1'b0; hold(3);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule